// File: doc/BRIEF.md
# DMA Bus Handshake Transfer Sequencer

This block moves data for one DMA channel. When a peripheral asks for service, the block requests the system bus from the host processor. It waits until the processor grants the bus, then tells the peripheral that its request is being served. Each transfer takes an address cycle followed by a strobe cycle. The strobe cycle drives one fixed pair of memory and I/O strobes, chosen by the transfer type. After each transfer the block steps the address and decrements the word count. It gives the bus back when the count runs out or when an end-of-process input arrives, and it records why the service ended in a terminal-count flag.

The address, the count, the step direction and the transfer type come in on configuration inputs. A `load` pulse copies them into the block while it is idle. The count is held as the number of transfers minus one. A slow device can hold `ready` low to lengthen the strobe cycle. If the processor takes the bus back in the middle of a service, the block finishes the strobe cycle it is in, drops its bus request, and keeps its address and count so that the next grant resumes where the service stopped. `rst_n` is an asynchronous active-low reset. The block expects it to have been synchronised to `clk` before it arrives, so that its release lines up with the clock.

Top module: `dma_seq`

## Requirements
- R1: In idle, with `tc` low and no `load`, a high `dreq` raises `hold_req` on the next clock. `dev_ack` and all strobes stay low until `hold_ack` is sampled high.
- R2: `dev_ack` goes high on the clock after `hold_ack` is sampled high. It stays high through every transfer and falls together with `hold_req` when the service ends. A strobe is never active while `dev_ack` is low.
- R3: Transfer type 2'b10 (memory to device) drives `mem_rd` and `io_wr` together in every strobe cycle. `mem_wr` and `io_rd` stay low.
- R4: Transfer type 2'b01 (device to memory) drives `mem_wr` and `io_rd` together in every strobe cycle. `mem_rd` and `io_wr` stay low.
- R5: Transfer type 2'b00 (verify) and the unused type 2'b11 drive no strobe. Their address cycles, strobe cycles, `ready` wait states, end-of-process handling and count handling are the same as for a real transfer.
- R6: Each transfer takes one address cycle and then at least one strobe cycle. `addr` stays the same during both. After the transfer, `addr` moves by +1 (`cfg_dec`=0) or by -1 (`cfg_dec`=1), modulo 2^ADDR_W.
- R7: A low `ready` on a strobe-cycle clock edge adds another strobe cycle with the same strobes and the same `addr`.
- R8: A loaded count C gives exactly C+1 transfers. The transfer in which the count wraps from zero to all ones ends the service: `hold_req` and `dev_ack` fall on the next clock and `tc` is set.
- R9: A high `eop` on the clock edge that completes a strobe cycle ends the service after that transfer, in the same way as R8, and sets `tc`.
- R10: If `hold_ack` is low on the edge that completes a strobe cycle, the block returns to idle with `hold_req` low. It keeps its address, count and `tc`, and a later grant continues the remaining transfers.
- R11: While `tc` is set, `dreq` is ignored and `hold_req` stays low. A `load` in idle copies the configuration inputs and clears `tc`.
- R12: A low `rst_n` immediately drives `hold_req`, `dev_ack`, all strobes and `tc` low and places the block in idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| load | input | 1 | Copies the configuration inputs; honoured only in idle |
| cfg_mode | input | 2 | Transfer type: 2'b10 memory to device, 2'b01 device to memory, 2'b00/2'b11 verify |
| cfg_dec | input | 1 | Address step direction: 0 counts up, 1 counts down |
| cfg_addr | input | ADDR_W | Start address |
| cfg_count | input | CNT_W | Number of transfers minus one |
| dreq | input | 1 | Peripheral service request |
| hold_ack | input | 1 | Bus grant from the host processor |
| ready | input | 1 | Low lengthens the strobe cycle |
| eop | input | 1 | End-of-process; ends the service after the current transfer |
| hold_req | output | 1 | Bus request to the host processor |
| dev_ack | output | 1 | Acknowledge to the peripheral |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| addr | output | ADDR_W | Current transfer address |
| tc | output | 1 | Terminal-count flag: the service ended by count or by end-of-process |

## Verification
The hardest case to reach is a bus grant withdrawn in the middle of a service. The processor has to drop `hold_ack` during one particular transfer's address cycle, and the block must then still complete that transfer's strobe cycle, leave the bus, and later resume with the address it had reached. The stimulus models the processor as a task that tracks address and strobe phases from `dev_ack`. It removes the grant in the address cycle of a chosen transfer, checks that the strobe cycle still completes, and then grants the bus again and checks that the remaining transfers continue from the address already reached. The same phase tracking places `ready` wait states and a one-edge `eop` pulse on exactly the strobe edge that a vector asks for.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REQ  = 2'b01,
    ST_ADDR = 2'b10,
    ST_STRB = 2'b11
  } seq_state_t;

  typedef enum logic [1:0] {
    XF_VERIFY = 2'b00,
    XF_WRITE  = 2'b01,
    XF_READ   = 2'b10,
    XF_RSVD   = 2'b11
  } xfer_t;

  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic io_rd;
    logic io_wr;
  } strobe_t;

endpackage

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_ok,
  input  logic       dreq,
  input  logic       hold_ack,
  input  logic       ready,
  input  logic       eop,
  input  logic       done,
  input  logic       last,
  output seq_state_t state,
  output logic       step,
  output logic       end_svc,
  output logic       hold_req,
  output logic       dev_ack
);

  seq_state_t state_d;

  assign step     = (state == ST_STRB) && ready;
  assign end_svc  = step && (eop || last);
  assign hold_req = (state != ST_IDLE);
  assign dev_ack  = (state == ST_ADDR) || (state == ST_STRB);

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: if (dreq && !done && !load_ok) state_d = ST_REQ;
      ST_REQ:  if (hold_ack) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_STRB;
      ST_STRB: begin
        if (ready) begin
          if (end_svc || !hold_ack) state_d = ST_IDLE;
          else                      state_d = ST_ADDR;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  // R1: no acknowledge while the grant is still awaited
  a_r1_no_ack_before_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REQ && !hold_ack) |=> !dev_ack);

  // R7: a low ready holds the strobe cycle
  a_r7_ready_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STRB && !ready) |=> (state == ST_STRB));

  // R9: end-of-process on a completing edge releases the bus
  a_r9_eop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (step && eop) |=> !hold_req);

  // R10: a withdrawn grant returns to idle after the strobe cycle
  a_r10_grant_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !hold_ack) |=> (state == ST_IDLE));

endmodule

// File: rtl/dma_seq_datapath.sv
module dma_seq_datapath
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_ok,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_dec,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              step,
  input  logic              end_svc,
  output logic [ADDR_W-1:0] addr_q,
  output xfer_t             mode_q,
  output logic              last,
  output logic              done_q
);

  localparam logic [ADDR_W-1:0] ADDR_UNIT = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_UNIT  = CNT_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ZERO  = '0;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_d;
  logic              dec_q;
  logic              done_d;
  logic              cnt_en, cfg_en, done_en;

  assign last    = (cnt_q == CNT_ZERO);
  assign cnt_en  = load_ok || step;
  assign cfg_en  = load_ok;
  assign done_en = load_ok || end_svc;

  always_comb begin
    if (load_ok) begin
      addr_d = cfg_addr;
      cnt_d  = cfg_count;
    end else begin
      addr_d = dec_q ? (addr_q - ADDR_UNIT) : (addr_q + ADDR_UNIT);
      cnt_d  = cnt_q - CNT_UNIT;
    end
    done_d = !load_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= XF_VERIFY;
      dec_q  <= 1'b0;
    end else if (cfg_en) begin
      mode_q <= xfer_t'(cfg_mode);
      dec_q  <= cfg_dec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       done_q <= 1'b0;
    else if (done_en) done_q <= done_d;
  end

  // R8: the wrapping transfer sets the terminal-count flag
  a_r8_tc_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last) |=> done_q);

  // R11: a load clears the terminal-count flag
  a_r11_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |=> !done_q);

endmodule

// File: rtl/dma_seq_strobe.sv
module dma_seq_strobe
  import dma_seq_pkg::*;
(
  input  seq_state_t state,
  input  xfer_t      mode,
  output strobe_t    strb
);

  always_comb begin
    strb = '0;
    if (state == ST_STRB) begin
      unique case (mode)
        XF_READ: begin
          strb.mem_rd = 1'b1;
          strb.io_wr  = 1'b1;
        end
        XF_WRITE: begin
          strb.mem_wr = 1'b1;
          strb.io_rd  = 1'b1;
        end
        default: strb = '0;
      endcase
    end
  end

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_dec,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              dreq,
  input  logic              hold_ack,
  input  logic              ready,
  input  logic              eop,
  output logic              hold_req,
  output logic              dev_ack,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              io_rd,
  output logic              io_wr,
  output logic [ADDR_W-1:0] addr,
  output logic              tc
);

  seq_state_t state;
  xfer_t      mode_q;
  strobe_t    strb;
  logic       step, end_svc, last, done_q, load_ok;

  assign load_ok = load && (state == ST_IDLE);

  dma_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_ok  (load_ok),
    .dreq     (dreq),
    .hold_ack (hold_ack),
    .ready    (ready),
    .eop      (eop),
    .done     (done_q),
    .last     (last),
    .state    (state),
    .step     (step),
    .end_svc  (end_svc),
    .hold_req (hold_req),
    .dev_ack  (dev_ack)
  );

  dma_seq_datapath #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_ok   (load_ok),
    .cfg_mode  (cfg_mode),
    .cfg_dec   (cfg_dec),
    .cfg_addr  (cfg_addr),
    .cfg_count (cfg_count),
    .step      (step),
    .end_svc   (end_svc),
    .addr_q    (addr),
    .mode_q    (mode_q),
    .last      (last),
    .done_q    (done_q)
  );

  dma_seq_strobe u_strb (
    .state (state),
    .mode  (mode_q),
    .strb  (strb)
  );

  assign mem_rd = strb.mem_rd;
  assign mem_wr = strb.mem_wr;
  assign io_rd  = strb.io_rd;
  assign io_wr  = strb.io_wr;
  assign tc     = done_q;

  // R2: strobes only inside an acknowledged bus tenure
  a_r2_strobe_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || io_rd || io_wr) |-> (dev_ack && hold_req));

  // R2: acknowledge follows a sampled grant
  a_r2_ack_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_ack) |-> $past(hold_ack));

  // R3: memory-to-device pairing
  a_r3_read_pair: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (io_wr && !mem_wr && !io_rd));

  // R4: device-to-memory pairing
  a_r4_write_pair: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (io_rd && !mem_rd && !io_wr));

  // R5: verify drives no strobe
  a_r5_verify_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == XF_VERIFY || mode_q == XF_RSVD) |-> !(mem_rd || mem_wr || io_rd || io_wr));

  // R7: address and strobes hold across a wait state
  a_r7_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr || io_rd || io_wr) && !ready) |=> ($stable(addr) && $stable(strb)));

endmodule

// File: tb/dma_seq_tb.sv
`timescale 1ns/1ps
module dma_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n, load, cfg_dec, dreq, hold_ack, ready, eop;
  logic [1:0]  cfg_mode;
  logic [15:0] cfg_addr, cfg_count;
  logic        hold_req, dev_ack, mem_rd, mem_wr, io_rd, io_wr, tc;
  logic [15:0] addr;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dma_seq #(.ADDR_W(16), .CNT_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .cfg_mode(cfg_mode), .cfg_dec(cfg_dec),
    .cfg_addr(cfg_addr), .cfg_count(cfg_count), .dreq(dreq), .hold_ack(hold_ack),
    .ready(ready), .eop(eop), .hold_req(hold_req), .dev_ack(dev_ack),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
    .addr(addr), .tc(tc)
  );

  typedef struct packed {
    logic [1:0]  md;
    logic        dec;
    logic [15:0] a;
    logic [15:0] c;
    logic [3:0]  w;
    logic [7:0]  e;
    logic [7:0]  nx;
    logic [15:0] fa;
  } vec_t;

  // mode, dec, start, count, waits, eop index (255 none), transfers, final address
  localparam vec_t VEC [6] = '{
    '{2'b10, 1'b0, 16'h1000, 16'd3, 4'd0, 8'd255, 8'd4, 16'h1004},
    '{2'b01, 1'b1, 16'h2000, 16'd2, 4'd1, 8'd255, 8'd3, 16'h1FFD},
    '{2'b00, 1'b0, 16'hFFFE, 16'd3, 4'd0, 8'd255, 8'd4, 16'h0002},
    '{2'b10, 1'b0, 16'h0100, 16'd9, 4'd2, 8'd2,   8'd3, 16'h0103},
    '{2'b01, 1'b0, 16'h0040, 16'd0, 4'd0, 8'd255, 8'd1, 16'h0041},
    '{2'b11, 1'b1, 16'h0005, 16'd5, 4'd1, 8'd0,   8'd1, 16'h0004}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_load(input logic [1:0] md, input logic dec,
                         input logic [15:0] a, input logic [15:0] c);
    @(negedge clk);
    load = 1'b1; cfg_mode = md; cfg_dec = dec; cfg_addr = a; cfg_count = c;
    @(negedge clk);
    load = 1'b0;
    chk(tc == 1'b0, "R11", "tc after load", int'(tc), 0);
  endtask

  // Processor and peripheral model for one bus tenure.
  task automatic run_service(input int gdelay, input int wcyc, input int eopi,
                             input int dropi, input logic [1:0] md,
                             input logic [15:0] start, input logic dec,
                             input int base, output int nx);
    int  ph = 0, wc = 0, gc = 0;
    bit  started = 0, granted = 0, just = 0;
    logic [3:0] exp_s, act_s;
    logic [15:0] ea;
    nx = 0;
    dreq = 1'b1;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      eop = 1'b0;
      if (c == 0) chk(hold_req == 1'b1, "R1", "hold_req after dreq", int'(hold_req), 1);
      if (hold_req) started = 1;
      if (started && !hold_req) begin
        chk(dev_ack == 1'b0, "R2", "dev_ack with bus released", int'(dev_ack), 0);
        break;
      end
      act_s = {mem_rd, mem_wr, io_rd, io_wr};
      if (just) begin
        chk(dev_ack == 1'b1, "R2", "dev_ack after grant", int'(dev_ack), 1);
        just = 0;
      end
      if (!granted) begin
        chk(dev_ack == 1'b0 && act_s == 4'b0, "R1", "quiet before grant",
            int'({dev_ack, act_s}), 0);
        if (gc == gdelay) begin hold_ack = 1'b1; granted = 1; just = 1; end
        else gc++;
      end else if (dev_ack) begin
        if (ph == 0) begin
          ea = dec ? start - 16'(base + nx) : start + 16'(base + nx);
          chk(addr == ea, "R6", "address in address cycle", int'(addr), int'(ea));
          chk(act_s == 4'b0, "R6", "no strobe in address cycle", int'(act_s), 0);
          if (dropi == nx) hold_ack = 1'b0;
          ph = 1; wc = 0;
        end else begin
          exp_s = (md == 2'b10) ? 4'b1001 : (md == 2'b01) ? 4'b0110 : 4'b0000;
          chk(act_s == exp_s,
              (md == 2'b10) ? "R3" : (md == 2'b01) ? "R4" : "R5",
              "strobe pair", int'(act_s), int'(exp_s));
          ea = dec ? start - 16'(base + nx) : start + 16'(base + nx);
          if (wc < wcyc) begin
            chk(addr == ea, "R7", "address held in wait", int'(addr), int'(ea));
            ready = 1'b0; wc++;
          end else begin
            ready = 1'b1;
            eop = (nx == eopi);
            nx++; ph = 0;
          end
        end
      end
    end
    hold_ack = 1'b0;
    ready = 1'b1;
    eop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int nx;
    rst_n = 1'b0; load = 1'b0; dreq = 1'b0; hold_ack = 1'b0; ready = 1'b1; eop = 1'b0;
    cfg_mode = 2'b00; cfg_dec = 1'b0; cfg_addr = '0; cfg_count = '0;
    repeat (3) @(negedge clk);
    chk({hold_req, dev_ack, mem_rd, mem_wr, io_rd, io_wr, tc} == 7'b0, "R12",
        "outputs in reset", int'({hold_req, dev_ack, mem_rd, mem_wr, io_rd, io_wr, tc}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table: R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 6; i++) begin
      do_load(VEC[i].md, VEC[i].dec, VEC[i].a, VEC[i].c);
      run_service(2, int'(VEC[i].w), int'(VEC[i].e), 255, VEC[i].md,
                  VEC[i].a, VEC[i].dec, 0, nx);
      dreq = 1'b0;
      chk(nx == int'(VEC[i].nx), (VEC[i].e == 8'd255) ? "R8" : "R9",
          "transfer count", nx, int'(VEC[i].nx));
      chk(addr == VEC[i].fa, "R6", "final address", int'(addr), int'(VEC[i].fa));
      chk(tc == 1'b1, (VEC[i].e == 8'd255) ? "R8" : "R9", "tc at end", int'(tc), 1);
      chk(hold_req == 1'b0, "R8", "bus released", int'(hold_req), 0);
    end

    // R11: requests ignored while tc is set
    dreq = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(hold_req == 1'b0, "R11", "dreq ignored after tc", int'(hold_req), 0);
    end
    dreq = 1'b0;

    // R10: grant withdrawn during the second transfer, then resumed
    do_load(2'b10, 1'b0, 16'h0300, 16'd5);
    run_service(0, 0, 255, 1, 2'b10, 16'h0300, 1'b0, 0, nx);
    chk(nx == 2, "R10", "transfers before release", nx, 2);
    chk(hold_req == 1'b0, "R10", "hold_req after lost grant", int'(hold_req), 0);
    chk(addr == 16'h0302, "R10", "address kept", int'(addr), 16'h0302);
    chk(tc == 1'b0, "R10", "tc not set by lost grant", int'(tc), 0);
    run_service(1, 0, 255, 255, 2'b10, 16'h0300, 1'b0, 2, nx);
    dreq = 1'b0;
    chk(nx == 4, "R10", "remaining transfers", nx, 4);
    chk(addr == 16'h0306, "R10", "final address after resume", int'(addr), 16'h0306);
    chk(tc == 1'b1, "R8", "tc after resumed service", int'(tc), 1);

    // R12: asynchronous reset in a strobe cycle
    do_load(2'b01, 1'b0, 16'h0400, 16'd3);
    dreq = 1'b1;
    for (int k = 0; k < 20 && !mem_wr; k++) begin
      @(negedge clk);
      if (hold_req) hold_ack = 1'b1;
    end
    chk(mem_wr == 1'b1, "R4", "strobe reached before reset", int'(mem_wr), 1);
    #1 rst_n = 1'b0;
    #0.5;
    chk({hold_req, dev_ack, mem_rd, mem_wr, io_rd, io_wr, tc} == 7'b0, "R12",
        "outputs on async reset", int'({hold_req, dev_ack, mem_rd, mem_wr, io_rd, io_wr, tc}), 0);
    dreq = 1'b0; hold_ack = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hold_req == 1'b0, "R12", "idle after reset", int'(hold_req), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule